// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of `WIDTH` bits with a single full-adder slice. It works on one bit position per clock, least significant bit first. Both operands are captured in parallel into two shift registers. Each enabled clock takes the low bit of each register and the stored carry, and forms a sum bit. That sum bit enters the top of the augend register while the register shifts right. After `WIDTH` enabled shifts, the augend register holds the sum and a carry flip-flop holds the carry out of the top bit.

The carry is kept in one flip-flop with set/reset/hold behaviour. It sets when both operand bits are 1, clears when both are 0, and otherwise keeps its value. A parameter selects what the addend register shifts in: zeros, or its own low bit (recirculation). The addend's final contents are not part of the result.

A load strobe starts an operation. A shift-enable paces it and can stall it for any number of cycles. A one-cycle done flag marks the moment the result becomes final. The block then ignores shift-enable until the next load. A synchronous clear returns everything to zero.

Top module: `serial_adder`

## Requirements
- R1: When `clr` is high at a rising edge, `result`, `carry_out` and `done` become 0 on that edge. The block is then idle, so `shift_en` has no effect until the next `start`. `clr` has priority over every other input.
- R2: When `start` is high (and `clr` low) at a rising edge, `result` takes `a_in`, the addend register takes `b_in`, and `carry_out` becomes 0. No shift happens on that edge, even when `shift_en` is also high.
- R3: Each enabled shift moves the augend right by one bit, and the new sum bit enters bit `WIDTH-1`. Bit 0 of each register is the current operand bit. After k enabled shifts (k < `WIDTH`), `result` equals `(A >> k)` with the low k bits of `A+B` placed in its top k positions.
- R4: On each enabled shift, `carry_out` becomes 1 if both operand bits are 1 and becomes 0 if both are 0. Otherwise it keeps its value. After k shifts it equals the carry out of the low k bits of `A+B`.
- R5: After exactly `WIDTH` enabled shifts, `result` equals `(A+B) mod 2^WIDTH` and `carry_out` equals bit `WIDTH` of `A+B` (for example 0x05 + 0x02 gives 0x07 with carry 0).
- R6: A cycle with `shift_en` low (and neither `clr` nor `start`) leaves `result` and `carry_out` unchanged. The operation resumes where it stopped.
- R7: `done` is high for exactly one cycle: the cycle that follows the edge of the `WIDTH`-th enabled shift. It is low at all other times.
- R8: Once the operation has finished, `shift_en` has no effect. `result` and `carry_out` stay unchanged until the next `start` or `clr`.
- R9: A `start` during an operation abandons it and begins a new one with the new operands and a cleared carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| start | input | 1 | Load both operands and begin an addition |
| shift_en | input | 1 | Process one bit position on this edge |
| a_in | input | WIDTH | Augend, parallel load value |
| b_in | input | WIDTH | Addend, parallel load value |
| done | output | 1 | One-cycle pulse when the sum is final |
| result | output | WIDTH | Augend register: partial or final sum |
| carry_out | output | 1 | Carry flip-flop |

## Verification
The hardest situations to reach from the ports are the intermediate states: a carry held across a mix of 0/1 bit pairs, and an operation stalled partway through. Every vector in the table is therefore checked after each single shift, against a partial sum and partial carry computed from the operands. Alternate vectors insert an idle cycle between shifts. Directed cases then press `start` in the middle of a run, raise `start` together with `shift_en`, and assert `clr` mid-run. Each of these is followed by extra `shift_en` pulses to show that idle state ignores them.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

   // What a shift register feeds into its top bit while shifting right
   typedef enum logic [1:0] {
      FILL_ZERO   = 2'd0,
      FILL_RECIRC = 2'd1,
      FILL_EXTERN = 2'd2
   } fill_e;

   // Width of a down-counter that must hold the value n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
   parameter int unsigned     WIDTH = 8,
   parameter sadd_pkg::fill_e FILL  = sadd_pkg::FILL_ZERO
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             shift,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q,
   output logic             ser_out
);

   logic [WIDTH-1:0] q_r;
   logic             fill_bit;

   if (WIDTH < 1) begin : g_bad_width
      $error("sadd_shreg: WIDTH must be at least 1");
   end

   if (FILL == sadd_pkg::FILL_EXTERN) begin : g_fill_ext
      assign fill_bit = ser_in;
   end else if (FILL == sadd_pkg::FILL_RECIRC) begin : g_fill_rec
      logic unused_ser;
      assign unused_ser = ser_in;
      assign fill_bit   = q_r[0];
   end else begin : g_fill_zero
      logic unused_ser;
      assign unused_ser = ser_in;
      assign fill_bit   = 1'b0;
   end

   if (WIDTH == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (clr)        q_r <= '0;
         else if (load)  q_r <= load_val;
         else if (shift) q_r <= fill_bit;
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (clr)        q_r <= '0;
         else if (load)  q_r <= load_val;
         else if (shift) q_r <= {fill_bit, q_r[WIDTH-1:1]};
      end
   end

   assign q       = q_r;
   assign ser_out = q_r[0];

endmodule

// File: rtl/sadd_slice.sv
module sadd_slice (
   input  logic clk,
   input  logic clr,
   input  logic load,
   input  logic step,
   input  logic x,
   input  logic y,
   output logic sum,
   output logic carry
);

   logic c_q;
   logic j_in;
   logic k_in;

   // Set when both bits are 1, reset when both are 0
   assign j_in = x & y;
   assign k_in = ~x & ~y;
   assign sum  = x ^ y ^ c_q;

   always_ff @(posedge clk) begin
      if (clr || load) begin
         c_q <= 1'b0;
      end else if (step) begin
         unique case ({j_in, k_in})
            2'b10:   c_q <= 1'b1;
            2'b01:   c_q <= 1'b0;
            2'b11:   c_q <= ~c_q;
            default: c_q <= c_q;
         endcase
      end
   end

   assign carry = c_q;

endmodule

// File: rtl/sadd_seq.sv
module sadd_seq #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned CW   = sadd_pkg::cnt_bits(WIDTH)
) (
   input  logic clk,
   input  logic clr,
   input  logic start,
   input  logic shift_en,
   output logic step,
   output logic busy,
   output logic done
);

   localparam logic [CW-1:0] FULL = CW'(WIDTH);
   localparam logic [CW-1:0] LAST = CW'(1);

   logic [CW-1:0] left_q;
   logic          busy_q;
   logic          done_q;

   assign step = busy_q & shift_en & ~start & ~clr;

   always_ff @(posedge clk) begin
      if (clr) begin
         left_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         left_q <= FULL;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (step) begin
         left_q <= left_q - LAST;
         busy_q <= (left_q != LAST);
         done_q <= (left_q == LAST);
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
   parameter int unsigned     WIDTH       = 8,
   parameter sadd_pkg::fill_e ADDEND_FILL = sadd_pkg::FILL_ZERO
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             start,
   input  logic             shift_en,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic             done,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   if (ADDEND_FILL == sadd_pkg::FILL_EXTERN) begin : g_bad_fill
      $error("serial_adder: addend register cannot take an external fill");
   end

   logic             step;
   logic             busy_w;
   logic             sum_bit;
   logic             aug_lsb;
   logic             add_lsb;
   logic [WIDTH-1:0] aug_q;
   logic [WIDTH-1:0] add_q;

   sadd_seq #(.WIDTH(WIDTH)) u_seq (
      .clk      (clk),
      .clr      (clr),
      .start    (start),
      .shift_en (shift_en),
      .step     (step),
      .busy     (busy_w),
      .done     (done)
   );

   sadd_shreg #(.WIDTH(WIDTH), .FILL(sadd_pkg::FILL_EXTERN)) u_aug (
      .clk      (clk),
      .clr      (clr),
      .load     (start),
      .load_val (a_in),
      .shift    (step),
      .ser_in   (sum_bit),
      .q        (aug_q),
      .ser_out  (aug_lsb)
   );

   sadd_shreg #(.WIDTH(WIDTH), .FILL(ADDEND_FILL)) u_add (
      .clk      (clk),
      .clr      (clr),
      .load     (start),
      .load_val (b_in),
      .shift    (step),
      .ser_in   (1'b0),
      .q        (add_q),
      .ser_out  (add_lsb)
   );

   sadd_slice u_fa (
      .clk   (clk),
      .clr   (clr),
      .load  (start),
      .step  (step),
      .x     (aug_lsb),
      .y     (add_lsb),
      .sum   (sum_bit),
      .carry (carry_out)
   );

   assign result = aug_q;

endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             clr,
   input logic             start,
   input logic             shift_en,
   input logic [WIDTH-1:0] a_in,
   input logic             done,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             busy,
   input logic             aug_lsb,
   input logic             add_lsb
);

   a_r1_clear: assert property (@(posedge clk)
      clr |=> (result == '0) && !carry_out && !done);

   a_r2_load: assert property (@(posedge clk) disable iff (clr)
      start |=> (result == $past(a_in)) && !carry_out && !done);

   a_r4_carry_set: assert property (@(posedge clk) disable iff (clr)
      (!start && busy && shift_en && aug_lsb && add_lsb) |=> carry_out);

   a_r4_carry_clr: assert property (@(posedge clk) disable iff (clr)
      (!start && busy && shift_en && !aug_lsb && !add_lsb) |=> !carry_out);

   a_r6_stall: assert property (@(posedge clk) disable iff (clr)
      (!start && !shift_en) |=> $stable(result) && $stable(carry_out));

   a_r7_single: assert property (@(posedge clk) disable iff (clr)
      done |=> !done);

   a_r7_after_run: assert property (@(posedge clk) disable iff (clr)
      $rose(done) |-> $past(busy) && $past(shift_en) && !busy);

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (clr)
      (!start && !busy) |=> $stable(result) && $stable(carry_out) && !done);

endmodule

bind serial_adder serial_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .clr       (clr),
   .start     (start),
   .shift_en  (shift_en),
   .a_in      (a_in),
   .done      (done),
   .result    (result),
   .carry_out (carry_out),
   .busy      (busy_w),
   .aug_lsb   (aug_lsb),
   .add_lsb   (add_lsb)
);

// File: tb/serial_adder_tb.sv
module serial_adder_tb;

   localparam int unsigned W  = 8;
   localparam int unsigned NV = 8;
   localparam logic [W-1:0] VA [NV] = '{8'h05, 8'hFF, 8'hFF, 8'h00, 8'h80, 8'hAA, 8'h3C, 8'h7F};
   localparam logic [W-1:0] VB [NV] = '{8'h02, 8'h01, 8'hFF, 8'h00, 8'h80, 8'h55, 8'hC3, 8'h01};

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         start = 1'b0;
   logic         shift_en = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         done;
   logic [W-1:0] result;
   logic         carry_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   serial_adder #(.WIDTH(W)) u_dut (
      .clk(clk), .clr(clr), .start(start), .shift_en(shift_en),
      .a_in(a_in), .b_in(b_in), .done(done), .result(result), .carry_out(carry_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   function automatic logic [W-1:0] partial(input logic [W-1:0] a, input logic [W-1:0] b, input int k);
      logic [W:0] s;
      logic [W:0] m;
      s = {1'b0, a} + {1'b0, b};
      m = (({{W{1'b0}}, 1'b1}) << k) - 1'b1;
      return W'(a >> k) | W'((s & m) << (W - k));
   endfunction

   function automatic logic pcarry(input logic [W-1:0] a, input logic [W-1:0] b, input int k);
      logic [W:0] m;
      logic [W:0] s;
      m = (({{W{1'b0}}, 1'b1}) << k) - 1'b1;
      s = ({1'b0, a} & m) + ({1'b0, b} & m);
      return s[k];
   endfunction

   task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit stall);
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b};
      a_in = a; b_in = b; start = 1'b1;
      tick();
      start = 1'b0;
      chk("R2 load result", result, a);
      chk("R2 load carry", carry_out, 1'b0);
      for (int k = 1; k <= W; k++) begin
         shift_en = 1'b1;
         tick();
         shift_en = 1'b0;
         if (k < W) begin
            chk("R3 partial result", result, partial(a, b, k));
            chk("R4 partial carry", carry_out, pcarry(a, b, k));
            chk("R7 done low mid-run", done, 1'b0);
            if (stall) begin
               tick();
               chk("R6 stall result", result, partial(a, b, k));
               chk("R6 stall carry", carry_out, pcarry(a, b, k));
            end
         end else begin
            chk("R5 sum", result, s[W-1:0]);
            chk("R5 carry", carry_out, s[W]);
            chk("R7 done pulse", done, 1'b1);
         end
      end
      shift_en = 1'b1;
      tick();
      chk("R7 done drops", done, 1'b0);
      chk("R8 result held", result, s[W-1:0]);
      chk("R8 carry held", carry_out, s[W]);
      tick();
      shift_en = 1'b0;
      chk("R8 still held", result, s[W-1:0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick();
      tick();
      clr = 1'b0;
      chk("R1 reset result", result, '0);
      chk("R1 reset carry", carry_out, 1'b0);
      chk("R1 reset done", done, 1'b0);
      shift_en = 1'b1;
      tick();
      shift_en = 1'b0;
      chk("R1 idle after reset", result, '0);
      chk("R1 no done after reset", done, 1'b0);

      for (int i = 0; i < NV; i++) run_add(VA[i], VB[i], (i % 2) == 1);

      // R9: restart in mid-run
      a_in = 8'hF0; b_in = 8'h0F; start = 1'b1;
      tick();
      start = 1'b0;
      shift_en = 1'b1;
      repeat (3) tick();
      shift_en = 1'b0;
      run_add(8'h19, 8'h27, 1'b0);
      chk("R9 restart sum", result, 8'h40);

      // R2: start together with shift_en performs no shift
      a_in = 8'h81; b_in = 8'h81; start = 1'b1; shift_en = 1'b1;
      tick();
      start = 1'b0; shift_en = 1'b0;
      chk("R2 start wins result", result, 8'h81);
      chk("R2 start wins carry", carry_out, 1'b0);

      // R1: clear mid-run, then shifting has no effect
      shift_en = 1'b1;
      tick();
      chk("R4 carry set", carry_out, 1'b1);
      clr = 1'b1;
      tick();
      clr = 1'b0;
      chk("R1 clear result", result, '0);
      chk("R1 clear carry", carry_out, 1'b0);
      repeat (W + 1) tick();
      shift_en = 1'b0;
      chk("R1 idle after clear", result, '0);
      chk("R1 no done after clear", done, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule